// File: doc/BRIEF.md
# Dual-Register Configurable Logic Cell

This block is one output cell of a small programmable logic fabric. Each of its registers owns a sum term built by OR-ing a configurable number of incoming product terms. Each register can be set up as a D or a T flip-flop, and each has its own asynchronous clear term. Each register is clocked either by its own product-term clock or by the shared clock pin. Both clock kinds are treated as enables: they fire on a rising edge, sampled on the single system clock. A shared synchronous preset, a test preload path and a power-up reset complete the register controls.

One register, index 0, or the raw sum term 0 can drive the bidirectional pin, which has its own output-enable term. Every register has a separate feedback output, so register 1 is a buried register. The pad value returns on an input path of its own.

Top module: `dual_reg_cell`

## Requirements
- R1: While `rst` is high at a system clock edge, every register clears to 0, and `fb_q` reads 0 after that edge.
- R2: In D mode (`cfg_tmode[i]=0`), on register i's active edge the register loads its sum term.
- R3: In T mode (`cfg_tmode[i]=1`), on an active edge the register inverts when its sum term is 1 and keeps its value when the sum term is 0.
- R4: The active edge is a rising edge, across two successive system clock samples, of `clk_pin` when `cfg_pinclk[i]=1`, or of `ptclk[i]` when `cfg_pinclk[i]=0`. Without such an edge the register holds its value.
- R5: While `areset_term[i]` is high, `fb_q[i]` reads 0 in that same cycle, and the register is 0 after the next system clock edge. This clear wins over every control except `rst`.
- R6: When `preload_en[i]` is high and `areset_term[i]` is low, the register takes `preload_val[i]` at the next system clock edge, with no active edge needed. Preload wins over preset and data.
- R7: When `sync_preset` is high on register i's active edge, with no clear or preload, the register becomes 1 whatever its D/T data would give.
- R8: Sum term i is the OR of product terms 0..N-1 of `pterm[i]`, where N is `cfg_nterms[i]` clamped to the range 4..8. Terms at N and above are ignored.
- R9: `pin_oe` follows `oe_term`. `pin_out` is sum term 0 when `cfg_comb_out=1`, and the visible value of register 0 (`fb_q[0]`) when `cfg_comb_out=0`.
- R10: `pin_fb` follows `pin_in` at all times, whatever the register state and the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| pterm | input | NREG*PT_MAX | Product-term values, one group per register |
| cfg_nterms | input | NREG*CNT_W | Product terms used per sum term (clamped to 4..8) |
| cfg_tmode | input | NREG | 1 = T type, 0 = D type, per register |
| cfg_pinclk | input | NREG | 1 = clock pin, 0 = private product-term clock |
| cfg_comb_out | input | 1 | 1 = pin driven by sum term 0, 0 = by register 0 |
| ptclk | input | NREG | Product-term clock per register |
| clk_pin | input | 1 | Shared dedicated clock pin |
| areset_term | input | NREG | Asynchronous clear term per register |
| sync_preset | input | 1 | Shared synchronous preset |
| preload_en | input | NREG | Test preload strobe per register |
| preload_val | input | NREG | Test preload value per register |
| oe_term | input | 1 | Output-enable product term |
| pin_in | input | 1 | Pad input value |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Pad driver enable |
| pin_fb | output | 1 | Pad input path into the array |
| fb_q | output | NREG | Register feedback into the array |

## Verification
The bench builds the cell with its default parameters: two registers, product-term groups eight wide and a four-bit term-count field. Because the field can hold any value from 0 to 15, random counts exercise both the lower clamp at four and the upper clamp at eight, as well as every count in between. With two registers, one register drives the pin while the other stays buried, and the two can be given different clock sources and D/T modes at once.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  typedef enum logic {
    SRC_TERM = 1'b0,
    SRC_PIN  = 1'b1
  } clk_src_e;

  typedef enum logic {
    KIND_D = 1'b0,
    KIND_T = 1'b1
  } flop_kind_e;
endpackage

// File: rtl/lcell_sum.sv
module lcell_sum #(
  parameter int PT_MIN = 4,
  parameter int PT_MAX = 8,
  parameter int CNT_W  = 4
) (
  input  logic [PT_MAX-1:0] terms,
  input  logic [CNT_W-1:0]  nsel,
  output logic              sum
);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(PT_MIN);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(PT_MAX);

  logic [CNT_W-1:0]  eff;
  logic [PT_MAX-1:0] used;

  always_comb begin
    if (nsel < LO_C)      eff = LO_C;
    else if (nsel > HI_C) eff = HI_C;
    else                  eff = nsel;
  end

  for (genvar k = 0; k < PT_MAX; k++) begin : g_slot
    assign used[k] = (eff > CNT_W'(k));
  end

  assign sum = |(terms & used);
endmodule

// File: rtl/lcell_edge.sv
module lcell_edge (
  input  logic clk,
  input  logic src,
  output logic rise
);
  logic prev;

  // Tracks the source even during reset so that no edge appears at release.
  always_ff @(posedge clk) prev <= src;

  assign rise = src & ~prev;
endmodule

// File: rtl/lcell_flop.sv
module lcell_flop
  import lcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  flop_kind_e kind,
  input  logic       fire,
  input  logic       data,
  input  logic       clr,
  input  logic       pl_en,
  input  logic       pl_val,
  input  logic       preset,
  output logic       q_vis
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (clr)   q <= 1'b0;
    else if (pl_en) q <= pl_val;
    else if (fire) begin
      if (preset)              q <= 1'b1;
      else if (kind == KIND_T) q <= q ^ data;
      else                     q <= data;
    end
  end

  // The clear term also hides the stored bit at once.
  assign q_vis = q & ~clr;
endmodule

// File: rtl/dual_reg_cell.sv
module dual_reg_cell
  import lcell_pkg::*;
#(
  parameter int NREG   = 2,
  parameter int PT_MIN = 4,
  parameter int PT_MAX = 8,
  parameter int CNT_W  = $clog2(PT_MAX + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NREG-1:0][PT_MAX-1:0]  pterm,
  input  logic [NREG-1:0][CNT_W-1:0]   cfg_nterms,
  input  logic [NREG-1:0]              cfg_tmode,
  input  logic [NREG-1:0]              cfg_pinclk,
  input  logic                         cfg_comb_out,
  input  logic [NREG-1:0]              ptclk,
  input  logic                         clk_pin,
  input  logic [NREG-1:0]              areset_term,
  input  logic                         sync_preset,
  input  logic [NREG-1:0]              preload_en,
  input  logic [NREG-1:0]              preload_val,
  input  logic                         oe_term,
  input  logic                         pin_in,
  output logic                         pin_out,
  output logic                         pin_oe,
  output logic                         pin_fb,
  output logic [NREG-1:0]              fb_q
);
  logic            pin_rise;
  logic [NREG-1:0] sums;

  lcell_edge u_pin_edge (.clk(clk), .src(clk_pin), .rise(pin_rise));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic       term_rise;
    logic       fire;
    clk_src_e   src;
    flop_kind_e kind;

    assign src  = clk_src_e'(cfg_pinclk[i]);
    assign kind = flop_kind_e'(cfg_tmode[i]);

    lcell_sum #(.PT_MIN(PT_MIN), .PT_MAX(PT_MAX), .CNT_W(CNT_W)) u_sum (
      .terms(pterm[i]), .nsel(cfg_nterms[i]), .sum(sums[i])
    );

    lcell_edge u_term_edge (.clk(clk), .src(ptclk[i]), .rise(term_rise));

    assign fire = (src == SRC_PIN) ? pin_rise : term_rise;

    lcell_flop u_flop (
      .clk(clk), .rst(rst), .kind(kind), .fire(fire), .data(sums[i]),
      .clr(areset_term[i]), .pl_en(preload_en[i]), .pl_val(preload_val[i]),
      .preset(sync_preset), .q_vis(fb_q[i])
    );
  end

  assign pin_out = cfg_comb_out ? sums[0] : fb_q[0];
  assign pin_oe  = oe_term;
  assign pin_fb  = pin_in;
endmodule

// File: rtl/lcell_checker.sv
module lcell_checker #(
  parameter int NREG = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NREG-1:0] cfg_pinclk,
  input logic [NREG-1:0] ptclk,
  input logic [NREG-1:0] areset_term,
  input logic            sync_preset,
  input logic [NREG-1:0] preload_en,
  input logic [NREG-1:0] preload_val,
  input logic [NREG-1:0] fb_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (fb_q == '0)); // R1

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
      areset_term[i] |=> !fb_q[i]); // R5

    AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (rst)
      (preload_en[i] && !areset_term[i])
      |=> (areset_term[i] || fb_q[i] == $past(preload_val[i]))); // R6

    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
      (!cfg_pinclk[i] && !(ptclk[i] && !$past(ptclk[i])) && !preload_en[i] && !areset_term[i])
      |=> (areset_term[i] || fb_q[i] == $past(fb_q[i]))); // R4

    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (rst)
      (sync_preset && !cfg_pinclk[i] && ptclk[i] && !$past(ptclk[i]) && !preload_en[i] && !areset_term[i])
      |=> (areset_term[i] || fb_q[i])); // R7
  end
endmodule

bind dual_reg_cell lcell_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .cfg_pinclk(cfg_pinclk), .ptclk(ptclk),
  .areset_term(areset_term), .sync_preset(sync_preset), .preload_en(preload_en),
  .preload_val(preload_val), .fb_q(fb_q)
);

// File: tb/sim_dual_reg_cell.sv
`timescale 1ns/1ps
module sim_dual_reg_cell;
  localparam int NREG = 2;
  localparam int PTM  = 8;
  localparam int CW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NREG-1:0][PTM-1:0] pterm = '0;
  logic [NREG-1:0][CW-1:0]  cfg_nterms = '0;
  logic [NREG-1:0] cfg_tmode = '0, cfg_pinclk = '0, ptclk = '0;
  logic [NREG-1:0] areset_term = '0, preload_en = '0, preload_val = '0;
  logic cfg_comb_out = 1'b0, clk_pin = 1'b0, sync_preset = 1'b0;
  logic oe_term = 1'b0, pin_in = 1'b0;
  logic pin_out, pin_oe, pin_fb;
  logic [NREG-1:0] fb_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit mq[NREG];
  bit mprev_pt[NREG];
  bit mprev_pin;

  always #2.5 clk = ~clk;

  dual_reg_cell u0 (
    .clk(clk), .rst(rst), .pterm(pterm), .cfg_nterms(cfg_nterms),
    .cfg_tmode(cfg_tmode), .cfg_pinclk(cfg_pinclk), .cfg_comb_out(cfg_comb_out),
    .ptclk(ptclk), .clk_pin(clk_pin), .areset_term(areset_term),
    .sync_preset(sync_preset), .preload_en(preload_en), .preload_val(preload_val),
    .oe_term(oe_term), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_fb(pin_fb), .fb_q(fb_q)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit msum(int i);
    int n = int'(cfg_nterms[i]);
    bit s = 0;
    if (n < 4) n = 4;
    if (n > 8) n = 8;
    for (int k = 0; k < n; k++) s |= pterm[i][k];
    return s;
  endfunction

  task automatic compare(string req);
    bit vis[NREG];
    for (int i = 0; i < NREG; i++) begin
      vis[i] = mq[i] & !areset_term[i];
      chk(req, $sformatf("fb_q[%0d]", i), int'(fb_q[i]), int'(vis[i]));
    end
    chk(req, "pin_out", int'(pin_out), int'(cfg_comb_out ? msum(0) : vis[0]));
    chk(req, "pin_oe", int'(pin_oe), int'(oe_term));
    chk(req, "pin_fb", int'(pin_fb), int'(pin_in));
  endtask

  task automatic model_step();
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        mq[i] = 0;
        mprev_pt[i] = ptclk[i];
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        bit e = cfg_pinclk[i] ? (clk_pin && !mprev_pin) : (ptclk[i] && !mprev_pt[i]);
        if (areset_term[i])     mq[i] = 0;
        else if (preload_en[i]) mq[i] = preload_val[i];
        else if (e) begin
          if (sync_preset)       mq[i] = 1;
          else if (cfg_tmode[i]) mq[i] = mq[i] ^ msum(i);
          else                   mq[i] = msum(i);
        end
        mprev_pt[i] = ptclk[i];
      end
    end
    mprev_pin = clk_pin;
  endtask

  // mode selects which controls are randomised
  task automatic drive(int mode);
    for (int i = 0; i < NREG; i++) begin
      pterm[i]       = PTM'($urandom);
      pterm[i][0]    = (mode == 8) ? 1'b0 : pterm[i][0];
      cfg_nterms[i]  = (mode == 8) ? CW'($urandom) : CW'(8);
      ptclk[i]       = $urandom % 2;
      cfg_tmode[i]   = (mode == 3) ? 1'b1 : ((mode >= 4) ? 1'($urandom) : 1'b0);
      cfg_pinclk[i]  = (mode >= 4) ? 1'($urandom) : 1'b0;
      areset_term[i] = (mode == 5 || mode >= 10) ? ($urandom % 4 == 0) : 1'b0;
      preload_en[i]  = (mode == 6 || mode >= 10) ? ($urandom % 4 == 0) : 1'b0;
      preload_val[i] = $urandom % 2;
    end
    clk_pin      = $urandom % 2;
    sync_preset  = (mode == 7 || mode >= 10) ? ($urandom % 3 == 0) : 1'b0;
    cfg_comb_out = (mode == 8) ? 1'b1 : ((mode >= 9) ? 1'($urandom) : 1'b0);
    oe_term      = $urandom % 2;
    pin_in       = $urandom % 2;
    rst          = (mode == 11) ? ($urandom % 8 == 0) : 1'b0;
  endtask

  task automatic run_phase(string req, int mode, int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      drive(mode);
      #1 compare(req);
      @(posedge clk);
      model_step();
    end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      mq[i] = 0;
      mprev_pt[i] = 0;
    end
    mprev_pin = 0;
    void'($urandom(32'd7));
    rst = 1'b1;
    repeat (3) begin
      @(posedge clk);
      model_step();
    end
    @(negedge clk);
    rst = 1'b0;
    #1 chk("R1", "fb_q after reset", int'(fb_q), 0);
    @(posedge clk);
    model_step();
    run_phase("R2", 2, 300);
    run_phase("R3", 3, 300);
    run_phase("R4", 4, 300);
    run_phase("R5", 5, 300);
    run_phase("R6", 6, 300);
    run_phase("R7", 7, 300);
    run_phase("R8", 8, 400);
    run_phase("R9", 9, 300);
    run_phase("R10", 10, 400);
    run_phase("R1", 11, 400);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule